// File: doc/BRIEF.md
# Predictive Fetch Address Generator

This block sits next to the instruction memory and produces the fetch address itself every cycle, so the memory does not have to wait for the processor to send one. It keeps a small fully associative table of branches. Each slot holds a source address, a target address and a direction bit. When the current fetch address matches a slot marked taken, the next generated address is the stored target and a one-bit predicted-taken flag goes back to the processor one cycle later. In every other case the generated address moves forward by one instruction.

The processor steers the block with a 2-bit code. The code 2'b10 means the processor has found a misprediction: the fetch address then comes straight from the processor's instruction address bus. Every other code keeps the generated address. The table trains itself from the address stream. Two cycles after an address is fetched, the address now on the processor's bus shows which instruction actually followed it. A taken branch that missed the table is inserted, and an entry that hit is rewritten in place. The block runs on the processor clock and has a synchronous reset.

Top module: `fetch_pred_gen`

## Requirements
- R1: When `steer_i` is 2'b10, `fetch_addr_o` equals `cpu_addr_i` in the same cycle. For the codes 2'b00, 2'b01 and 2'b11, `fetch_addr_o` is the internally generated address.
- R2: If the fetch address matches a valid entry marked taken, then in the next cycle `pred_taken_o` is 1 and the generated address is that entry's target.
- R3: If the fetch address misses the table, or matches an entry marked not-taken, then in the next cycle `pred_taken_o` is 0 and the generated address is the fetch address plus `STEP` (4 by default).
- R4: Two cycles after a fetch at address P, the successor of P is observed. It is `cpu_addr_i` when `steer_i` is 2'b10, and `cpu_addr_i - STEP` otherwise. The branch at P counts as resolved taken exactly when the successor differs from P + `STEP`.
- R5: When P missed the table and resolves taken, a new entry {source P, target = successor, taken} is written. No address ever matches more than one valid entry.
- R6: When P hit the table, its entry is rewritten in place: marked not-taken when P resolves not-taken, and marked taken with the new successor as target otherwise.
- R7: An insertion uses the lowest-numbered free entry. When all entries are valid, the victim is chosen round-robin, starting at entry 0 after reset. The number of valid entries never decreases outside reset.
- R8: A cycle with `steer_i` = 2'b10 cancels training for the fetch made one cycle earlier, because that fetch was on the wrong path. No entry is created or changed for it.
- R9: A synchronous reset clears every table entry and `pred_taken_o`, and loads the generated address with `RESET_VEC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the processor |
| rst | input | 1 | Synchronous reset, active high |
| steer_i | input | 2 | Steering code from the processor; 2'b10 redirects to the bus address |
| cpu_addr_i | input | AW | Processor instruction address bus |
| fetch_addr_o | output | AW | Address presented to the instruction memory this cycle |
| pred_taken_o | output | 1 | Set when the previous fetch was predicted as a taken branch |

## Verification
The hardest state to reach from the ports is a full table in which the round-robin victim pointer has to evict a live entry. The same applies to a redirect that must cancel the wrong-path fetch one cycle before it. Random addresses rarely produce either one in a controlled way. The stimulus therefore teaches nine distinct taken branches with a fixed three-cycle redirect pattern, which forces an eviction. It then probes the evicted source and a surviving source, and a directed sequence places a far bus address right after a redirect, so a missing cancellation would insert a bogus entry. A seeded random phase then mixes all four steering codes over a small address pool, so entries hit, miss, flip direction and get evicted often.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
   // steering code that forces the fetch address from the processor bus
   localparam logic [1:0] STEER_REDIRECT = 2'b10;

   typedef enum logic [1:0] {
      TRAIN_IDLE   = 2'b00,
      TRAIN_UPDATE = 2'b01,
      TRAIN_INSERT = 2'b10
   } train_op_e;
endpackage

// File: rtl/fpg_btb.sv
module fpg_btb #(
   parameter int AW      = 32,
   parameter int ENTRIES = 8,
   parameter int IW      = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [AW-1:0]      lk_addr,
   output logic               lk_hit,
   output logic [IW-1:0]      lk_idx,
   output logic               lk_taken,
   output logic [AW-1:0]      lk_target,
   output logic [ENTRIES-1:0] hit_vec,
   output logic [ENTRIES-1:0] valid_vec,
   input  logic               wr_en,
   input  logic [IW-1:0]      wr_idx,
   input  logic [AW-1:0]      wr_src,
   input  logic [AW-1:0]      wr_tgt,
   input  logic               wr_taken
);
   logic [AW-1:0] tgt_arr [ENTRIES];
   logic          dir_arr [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic          v_q;
      logic          t_q;
      logic [AW-1:0] s_q;
      logic [AW-1:0] g_q;
      logic          sel;

      assign sel = wr_en && (wr_idx == IW'(e));

      always_ff @(posedge clk) begin
         if (rst) begin
            v_q <= 1'b0;
         end else if (sel) begin
            v_q <= 1'b1;
            s_q <= wr_src;
            g_q <= wr_tgt;
            t_q <= wr_taken;
         end
      end

      assign hit_vec[e]   = v_q && (s_q == lk_addr);
      assign valid_vec[e] = v_q;
      assign tgt_arr[e]   = g_q;
      assign dir_arr[e]   = t_q;
   end

   // at most one slot matches, so an OR merge acts as the read mux
   always_comb begin
      lk_idx    = '0;
      lk_target = '0;
      lk_taken  = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            lk_idx    = lk_idx | IW'(i);
            lk_target = lk_target | tgt_arr[i];
            lk_taken  = lk_taken | dir_arr[i];
         end
      end
   end

   assign lk_hit = |hit_vec;
endmodule

// File: rtl/fpg_victim.sv
module fpg_victim #(
   parameter int ENTRIES = 8,
   parameter int IW      = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic               alloc,
   output logic [IW-1:0]      victim_idx
);
   localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

   logic          free_any;
   logic [IW-1:0] free_idx;
   logic [IW-1:0] rr_q;

   // lowest free slot wins: scan from the top so the last hit is the lowest
   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            free_any = 1'b1;
            free_idx = IW'(i);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rr_q <= '0;
      end else if (alloc && !free_any) begin
         rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
      end
   end

   assign victim_idx = free_any ? free_idx : rr_q;
endmodule

// File: rtl/fpg_history.sv
module fpg_history #(
   parameter int AW = 32,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          kill,
   input  logic [AW-1:0] push_pc,
   input  logic          push_hit,
   input  logic [IW-1:0] push_idx,
   input  logic          ins_en,
   input  logic [AW-1:0] ins_src,
   input  logic [IW-1:0] ins_idx,
   output logic          old_vld,
   output logic [AW-1:0] old_pc,
   output logic          old_hit,
   output logic [IW-1:0] old_idx
);
   logic          y_vld;
   logic [AW-1:0] y_pc;
   logic          y_hit;
   logic [IW-1:0] y_idx;

   // keep in-flight hit info coherent with an insertion made this cycle
   function automatic logic [IW:0] refresh(input logic [AW-1:0] pc,
                                           input logic hit,
                                           input logic [IW-1:0] idx);
      if (ins_en && (pc == ins_src))
         return {1'b1, ins_idx};
      else if (ins_en && hit && (idx == ins_idx))
         return {1'b0, idx};
      else
         return {hit, idx};
   endfunction

   logic [IW:0] push_fix;
   logic [IW:0] young_fix;

   assign push_fix  = refresh(push_pc, push_hit, push_idx);
   assign young_fix = refresh(y_pc, y_hit, y_idx);

   always_ff @(posedge clk) begin
      if (rst) begin
         y_vld   <= 1'b0;
         old_vld <= 1'b0;
      end else begin
         y_vld   <= 1'b1;
         old_vld <= y_vld && !kill;
      end
   end

   always_ff @(posedge clk) begin
      y_pc    <= push_pc;
      y_hit   <= push_fix[IW];
      y_idx   <= push_fix[IW-1:0];
      old_pc  <= y_pc;
      old_hit <= young_fix[IW];
      old_idx <= young_fix[IW-1:0];
   end
endmodule

// File: rtl/fetch_pred_gen.sv
module fetch_pred_gen #(
   parameter int          AW        = 32,
   parameter int          ENTRIES   = 8,
   parameter int unsigned STEP      = 4,
   parameter logic [AW-1:0] RESET_VEC = 32'h8000_0000
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [1:0]    steer_i,
   input  logic [AW-1:0] cpu_addr_i,
   output logic [AW-1:0] fetch_addr_o,
   output logic          pred_taken_o
);
   import fpg_pkg::*;

   localparam int            IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [AW-1:0] STEP_A = AW'(STEP);

   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("fetch_pred_gen: ENTRIES must lie in 2..64");
   end
   if (AW < 8) begin : g_bad_aw
      $error("fetch_pred_gen: AW must be at least 8");
   end
   if (STEP == 0 || (STEP & (STEP - 1)) != 0) begin : g_bad_step
      $error("fetch_pred_gen: STEP must be a power of two");
   end

   logic               redirect;
   logic [AW-1:0]      gen_pc_q;
   logic               pred_q;
   logic               lk_hit, lk_taken;
   logic [IW-1:0]      lk_idx;
   logic [AW-1:0]      lk_target;
   logic [ENTRIES-1:0] hit_vec, valid_vec;

   assign redirect     = (steer_i == STEER_REDIRECT);
   assign fetch_addr_o = redirect ? cpu_addr_i : gen_pc_q;
   assign pred_taken_o = pred_q;

   // training side
   logic          old_vld, old_hit;
   logic [AW-1:0] old_pc;
   logic [IW-1:0] old_idx;
   logic [AW-1:0] successor;
   logic          res_taken;
   logic [IW-1:0] victim_idx;
   train_op_e     op;
   logic          wr_en;
   logic [IW-1:0] wr_idx;

   fpg_btb #(.AW(AW), .ENTRIES(ENTRIES), .IW(IW)) u_btb (
      .clk       (clk),
      .rst       (rst),
      .lk_addr   (fetch_addr_o),
      .lk_hit    (lk_hit),
      .lk_idx    (lk_idx),
      .lk_taken  (lk_taken),
      .lk_target (lk_target),
      .hit_vec   (hit_vec),
      .valid_vec (valid_vec),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_src    (old_pc),
      .wr_tgt    (successor),
      .wr_taken  (res_taken)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         gen_pc_q <= RESET_VEC;
         pred_q   <= 1'b0;
      end else if (lk_hit && lk_taken) begin
         gen_pc_q <= lk_target;
         pred_q   <= 1'b1;
      end else begin
         gen_pc_q <= fetch_addr_o + STEP_A;
         pred_q   <= 1'b0;
      end
   end

   assign successor = redirect ? cpu_addr_i : cpu_addr_i - STEP_A;
   assign res_taken = (successor != old_pc + STEP_A);

   always_comb begin
      op = TRAIN_IDLE;
      if (old_vld) begin
         if (old_hit)        op = TRAIN_UPDATE;
         else if (res_taken) op = TRAIN_INSERT;
      end
   end

   assign wr_en  = (op != TRAIN_IDLE);
   assign wr_idx = (op == TRAIN_UPDATE) ? old_idx : victim_idx;

   fpg_victim #(.ENTRIES(ENTRIES), .IW(IW)) u_victim (
      .clk        (clk),
      .rst        (rst),
      .valid_vec  (valid_vec),
      .alloc      (op == TRAIN_INSERT),
      .victim_idx (victim_idx)
   );

   fpg_history #(.AW(AW), .IW(IW)) u_hist (
      .clk      (clk),
      .rst      (rst),
      .kill     (redirect),
      .push_pc  (fetch_addr_o),
      .push_hit (lk_hit),
      .push_idx (lk_idx),
      .ins_en   (op == TRAIN_INSERT),
      .ins_src  (old_pc),
      .ins_idx  (victim_idx),
      .old_vld  (old_vld),
      .old_pc   (old_pc),
      .old_hit  (old_hit),
      .old_idx  (old_idx)
   );
endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
   parameter int          AW      = 32,
   parameter int          ENTRIES = 8,
   parameter int unsigned STEP    = 4
) (
   input logic               clk,
   input logic               rst,
   input logic [1:0]         steer_i,
   input logic [AW-1:0]      fetch_addr_o,
   input logic               pred_taken_o,
   input logic [ENTRIES-1:0] hit_vec,
   input logic [ENTRIES-1:0] valid_vec
);
   logic seen;

   always_ff @(posedge clk) begin
      if (rst) seen <= 1'b0;
      else     seen <= 1'b1;
   end

   // R3: without a prediction and without redirect, fetch advances by one step
   p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
      (seen && steer_i != 2'b10 && !pred_taken_o)
      |-> fetch_addr_o == $past(fetch_addr_o) + AW'(STEP));

   // R2: a taken prediction never lands on the plain successor
   p_taken_jump_r2: assert property (@(posedge clk) disable iff (rst)
      (seen && steer_i != 2'b10 && pred_taken_o)
      |-> fetch_addr_o != $past(fetch_addr_o) + AW'(STEP));

   // R5: no address matches two slots
   p_unique_hit_r5: assert property (@(posedge clk) disable iff (rst)
      $countones(hit_vec) <= 1);

   // R7: occupancy only grows outside reset
   p_fill_grows_r7: assert property (@(posedge clk) disable iff (rst)
      seen |-> $countones(valid_vec) >= $countones($past(valid_vec)));

   // R9: leaving reset, table empty and no prediction
   p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!pred_taken_o && valid_vec == '0));
endmodule

bind fetch_pred_gen fpg_checker #(.AW(AW), .ENTRIES(ENTRIES), .STEP(STEP)) u_fpg_chk (
   .clk          (clk),
   .rst          (rst),
   .steer_i      (steer_i),
   .fetch_addr_o (fetch_addr_o),
   .pred_taken_o (pred_taken_o),
   .hit_vec      (hit_vec),
   .valid_vec    (valid_vec)
);

// File: tb/test_fetch_pred_gen.sv
module test_fetch_pred_gen;
   localparam int          AW = 32;
   localparam int          N  = 8;
   localparam logic [31:0] RV = 32'h8000_0000;

   logic          clk = 1'b0;
   logic          rst;
   logic [1:0]    steer;
   logic [AW-1:0] addr;
   logic [AW-1:0] fetch;
   logic          pred;

   always #2 clk = ~clk;

   fetch_pred_gen #(.AW(AW), .ENTRIES(N), .STEP(4), .RESET_VEC(RV)) i_fetch_pred_gen (
      .clk(clk), .rst(rst), .steer_i(steer), .cpu_addr_i(addr),
      .fetch_addr_o(fetch), .pred_taken_o(pred));

   int n_chk = 0, n_fail = 0;

   // reference model built from the requirements
   bit          mv [N];
   bit          mt [N];
   logic [31:0] ms [N];
   logic [31:0] mg [N];
   int          mrr;
   logic [31:0] mgen;
   bit          mpred, h1v, h2v;
   logic [31:0] h1p, h2p;

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int mfind(input logic [31:0] a);
      for (int i = 0; i < N; i++) if (mv[i] && ms[i] == a) return i;
      return -1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < N; i++) mv[i] = 0;
      mrr = 0; mgen = RV; mpred = 0; h1v = 0; h2v = 0;
   endtask

   // drive at negedge, compare just after (R1 selects the fetch source)
   task automatic apply(input logic [1:0] s, input logic [31:0] a, input string req);
      steer = s; addr = a;
      #1;
      check(req, "fetch", fetch, (s == 2'b10) ? a : mgen);
      check(req, "pred", {31'b0, pred}, {31'b0, mpred});
   endtask

   task automatic advance();
      logic [31:0] f, ngen, succ;
      bit npred, redir, tk;
      int k, j, v;
      redir = (steer == 2'b10);
      f = redir ? addr : mgen;
      k = mfind(f);
      if (k >= 0 && mt[k]) begin ngen = mg[k]; npred = 1; end   // R2
      else begin ngen = f + 4; npred = 0; end                    // R3
      if (h2v) begin                                              // R4
         succ = redir ? addr : addr - 4;
         tk = (succ != h2p + 4);
         j = mfind(h2p);
         if (j >= 0) begin mg[j] = succ; mt[j] = tk; end         // R6
         else if (tk) begin                                       // R5, R7
            v = -1;
            for (int i = 0; i < N; i++) if (!mv[i] && v < 0) v = i;
            if (v < 0) begin v = mrr; mrr = (mrr + 1) % N; end
            mv[v] = 1; ms[v] = h2p; mg[v] = succ; mt[v] = 1;
         end
      end
      h2v = h1v && !redir;                                        // R8
      h2p = h1p; h1v = 1; h1p = f;
      mgen = ngen; mpred = npred;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic step(input logic [1:0] s, input logic [31:0] a, input string req);
      apply(s, a, req);
      advance();
   endtask

   task automatic do_reset();
      rst = 1; steer = 2'b00; addr = '0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      rst = 0;
      model_reset();
   endtask

   // fetch src, then redirect to dst two cycles later: trains src -> dst
   task automatic teach(input logic [31:0] src, input logic [31:0] dst, input string req);
      step(2'b10, src, req);
      step(2'b00, 32'h0, req);
      step(2'b10, dst, req);
   endtask

   // probe src; trailing redirects leave no trainable record behind
   task automatic probe(input logic [31:0] src, input bit exp_tk, input logic [31:0] exp_f, input string req);
      step(2'b10, src, req);
      apply(2'b00, 32'h0, req);
      check(req, "probe pred", {31'b0, pred}, {31'b0, exp_tk});
      check(req, "probe fetch", fetch, exp_f);
      advance();
      step(2'b10, src + 4, req);
      step(2'b10, src + 8, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      do_reset();
      // R9: reset state
      apply(2'b00, 32'h0, "R9");
      check("R9", "reset pc", fetch, RV);
      check("R9", "reset pred", {31'b0, pred}, 32'h0);
      advance();
      // R3: sequential run
      step(2'b00, 32'h0, "R3");
      apply(2'b00, 32'h0, "R3");
      check("R3", "seq", fetch, RV + 8);
      advance();
      step(2'b01, 32'h1234_0000, "R1");
      step(2'b11, 32'h1234_0000, "R1");
      // R1: redirect
      apply(2'b10, 32'h8000_1000, "R1");
      check("R1", "redirect", fetch, 32'h8000_1000);
      advance();
      // R5, R2: insert then predict
      teach(32'h8000_2000, 32'h8000_3000, "R5");
      probe(32'h8000_2000, 1, 32'h8000_3000, "R2");
      // R6: probe's trailing step retrained the branch not-taken
      probe(32'h8000_2000, 0, 32'h8000_2004, "R6");
      teach(32'h8000_2000, 32'h8000_3800, "R6");
      probe(32'h8000_2000, 1, 32'h8000_3800, "R6");
      teach(32'h8000_2000, 32'h8000_3800, "R5");
      probe(32'h8000_2000, 1, 32'h8000_3800, "R5");
      // R8: wrong-path fetch at X+4 must not be trained from the far bus value
      step(2'b10, 32'h8000_5000, "R8");
      step(2'b00, 32'h0, "R8");
      step(2'b10, 32'h8000_6000, "R8");
      step(2'b00, 32'h8000_9000, "R8");
      probe(32'h8000_5004, 0, 32'h8000_5008, "R8");
      // R7: fill all slots, then evict slot 0
      do_reset();
      for (int i = 0; i < 9; i++)
         teach(32'h8001_0000 + i * 32'h100, 32'h8002_0000 + i * 32'h100, "R7");
      probe(32'h8001_0000, 0, 32'h8001_0004, "R7");
      probe(32'h8001_0100, 1, 32'h8002_0100, "R7");
      probe(32'h8001_0800, 1, 32'h8002_0800, "R7");
      // R4: seeded random mix over a small address pool
      for (int c = 0; c < 3000; c++) begin
         int r;
         logic [1:0] s;
         r = $urandom % 8;
         s = (r < 5) ? 2'b00 : (r == 5) ? 2'b01 : (r == 6) ? 2'b11 : 2'b10;
         step(s, 32'h8000_0400 + 4 * ($urandom % 24), "R4");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule